// File: doc/BRIEF.md
# Two-Wire Slave Receive Engine with Host-Decided Acknowledge

This block is the receive half of a two-wire serial slave (SMBus/I2C style). It oversamples the clock and data lines with the system clock, cleans them through a synchronizer and a short majority-free glitch filter, and recognises START (data falling while the clock is high) and STOP (data rising while the clock is high). After a START it shifts in eight bits, most significant first: seven address bits and a direction bit, and then any number of data bytes.

When the address carries the write direction and slave events are not inhibited, the engine enters receive mode. For every byte it accepts, it raises an event flag and an acknowledge-request bit as soon as the eighth bit has been clocked in. This happens before the acknowledge clock. The host then writes an acknowledge decision and clears the flag. If the bus master pulls the clock low for the acknowledge slot while the decision is still pending, the engine holds the clock line low (stretching) until the host has answered. It then drives the chosen level on the data line during the ninth clock. A refused address makes the engine deaf until the next START. A STOP ends receive mode. A host write to the data register during receive mode raises a request to switch to the transmit side, which is handled elsewhere.

Top module: `twi_slave_rx`

## Requirements
- R1: After reset, all outputs are 0 and the engine ignores bus activity until a START is seen.
- R2: A START followed by eight bits whose last bit is 0, with `inhibit` low, sets `eventFlag`, `ackReq`, `rxIsAddr` and `rxActive` during the high phase of the eighth clock. This is before the ninth clock begins. `rxData` then holds the eight received bits, the first bit in bit 7.
- R3: In the ninth clock of an accepted byte, `sdaPullLow` is 1 if the host last wrote `ackVal`=1 and 0 if it wrote `ackVal`=0.
- R4: If `eventFlag` or `ackReq` is still set when SCL falls after the eighth bit, `sclHoldLow` goes to 1. It returns to 0 one clock after the edge at which the later of `flagClr` and `ackWr` is sampled, and `sdaPullLow` takes the decided level on that same edge.
- R5: If the host has decided before SCL falls after the eighth bit, `sclHoldLow` stays 0 through the acknowledge slot.
- R6: After a refused address (`ackVal`=0), no further event is raised and nothing is driven until the next START. A repeated START restores normal reception.
- R7: Each data byte after an acknowledged address raises `eventFlag` and `ackReq` with `rxIsAddr`=0 and the byte in `rxData`. A refused data byte leaves `rxActive` at 1.
- R8: With `inhibit`=1 when the address byte completes, no event is raised, `rxActive` stays 0, and neither line is driven until the next START.
- R9: An address whose direction bit is 1 (read) raises no event and is not acknowledged.
- R10: A STOP clears `rxActive`. Bytes clocked after it without a new START raise no event.
- R11: A `dataWr` pulse while `rxActive` is 1 sets `txSwitch`, which stays set until the next STOP or START. A `dataWr` pulse while `rxActive` is 0 has no effect.
- R12: A clock-line pulse lasting 2 system clocks or less is ignored and shifts no bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Sampled level of the serial clock line |
| sdaIn | input | 1 | Sampled level of the serial data line |
| inhibit | input | 1 | 1 suppresses slave events for the address being received |
| ackWr | input | 1 | Host strobe: write acknowledge decision, clears `ackReq` |
| ackVal | input | 1 | Decision written by `ackWr`: 1 acknowledge, 0 refuse |
| flagClr | input | 1 | Host strobe clearing `eventFlag` |
| dataWr | input | 1 | Host strobe: write to the data register |
| sclHoldLow | output | 1 | 1 pulls the clock line low (stretch) |
| sdaPullLow | output | 1 | 1 pulls the data line low |
| eventFlag | output | 1 | Byte-complete event pending for the host |
| ackReq | output | 1 | Acknowledge decision pending |
| rxIsAddr | output | 1 | Last latched byte was an address |
| rxActive | output | 1 | Receive mode active |
| txSwitch | output | 1 | Request to switch to slave transmit |
| rxData | output | 8 | Last accepted byte |

## Verification
A wrong bit count or a missed edge makes the engine acknowledge on the wrong clock. The bench sees this within one byte, as a wrong `sdaPullLow` level in the ninth clock or an event that is missing or comes after the eighth high phase. A stale decision or a stretch flag that is never cleared shows as `sclHoldLow` staying high one clock after the host has answered. That would hang the master model, so the timing is checked to the exact system clock. A state left in the wrong mode after a refused address, an inhibit or a STOP shows on the very next byte, as an event or a driven line where none is allowed.

// File: rtl/twi_rx_pkg.sv
package twi_rx_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 2);

  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic start;
    logic stop;
  } busEvt_t;

  typedef struct packed {
    logic latchByte;
    logic pullSda;
    logic freeSda;
    logic holdScl;
    logic freeScl;
  } dpCtl_t;

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_DATA, ST_SKIP} rxState_t;
endpackage

// File: rtl/twi_line_filter.sv
module twi_line_filter #(
  parameter int SYNC_N = 2,
  parameter int FILT_N = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  output logic lineOut
);
  logic [SYNC_N-1:0] syncQ;
  logic [FILT_N-1:0] histQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ   <= '1;
      histQ   <= '1;
      lineOut <= 1'b1;
    end else begin
      syncQ <= {syncQ[SYNC_N-2:0], lineIn};
      histQ <= {histQ[FILT_N-2:0], syncQ[SYNC_N-1]};
      if (&histQ)       lineOut <= 1'b1;
      else if (~|histQ) lineOut <= 1'b0;
    end
  end
endmodule

// File: rtl/twi_rx_dpath.sv
module twi_rx_dpath import twi_rx_pkg::*; #(
  parameter int SYNC_N = 2,
  parameter int FILT_N = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  dpCtl_t            ctl,
  output busEvt_t           evt,
  output logic              curBit,
  output logic [BYTE_W-1:0] rxData,
  output logic              sdaPullLow,
  output logic              sclHoldLow
);
  localparam int LINES = 2;

  logic [LINES-1:0] rawLine, cleanLine;
  logic sdaF, sclF, sdaPrev, sclPrev;
  logic [BYTE_W-1:0] shReg;

  assign rawLine = {sclIn, sdaIn};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    twi_line_filter #(.SYNC_N(SYNC_N), .FILT_N(FILT_N)) u_filt (
      .clk(clk), .rstN(rstN), .lineIn(rawLine[g]), .lineOut(cleanLine[g])
    );
  end

  assign sdaF   = cleanLine[0];
  assign sclF   = cleanLine[1];
  assign curBit = sdaF;

  always_comb begin
    evt.sclRise = sclF && !sclPrev;
    evt.sclFall = !sclF && sclPrev;
    evt.start   = sclF && sclPrev && sdaPrev && !sdaF;
    evt.stop    = sclF && sclPrev && !sdaPrev && sdaF;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sdaPrev    <= 1'b1;
      sclPrev    <= 1'b1;
      shReg      <= '0;
      rxData     <= '0;
      sdaPullLow <= 1'b0;
      sclHoldLow <= 1'b0;
    end else begin
      sdaPrev <= sdaF;
      sclPrev <= sclF;
      if (evt.sclRise) shReg <= {shReg[BYTE_W-2:0], sdaF};
      if (ctl.latchByte) rxData <= {shReg[BYTE_W-2:0], sdaF};
      if (ctl.freeSda)      sdaPullLow <= 1'b0;
      else if (ctl.pullSda) sdaPullLow <= 1'b1;
      if (ctl.freeScl)      sclHoldLow <= 1'b0;
      else if (ctl.holdScl) sclHoldLow <= 1'b1;
    end
  end

  // R3: the acknowledge level is applied only while the clock is low
  a_r3_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPullLow) |-> !sclF);
endmodule

// File: rtl/twi_rx_ctrl.sv
module twi_rx_ctrl import twi_rx_pkg::*; (
  input  logic    clk,
  input  logic    rstN,
  input  busEvt_t evt,
  input  logic    curBit,
  input  logic    inhibit,
  input  logic    ackWr,
  input  logic    ackVal,
  input  logic    flagClr,
  input  logic    dataWr,
  output dpCtl_t  ctl,
  output logic    eventFlag,
  output logic    ackReq,
  output logic    rxIsAddr,
  output logic    rxActive,
  output logic    txSwitch
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] SLOT_CNT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] END_CNT  = CNT_W'(BYTE_W + 1);

  rxState_t state;
  logic [CNT_W-1:0] bitCnt;
  logic ackBit, waitSlot;
  logic engaged, byteDone, accept, slotOpen, slotEnd, decided;

  assign engaged  = (state == ST_ADDR) || (state == ST_DATA);
  assign byteDone = evt.sclRise && engaged && (bitCnt == LAST_BIT);
  assign accept   = byteDone && ((state == ST_DATA) || (!curBit && !inhibit));
  assign slotOpen = evt.sclFall && engaged && (bitCnt == SLOT_CNT);
  assign slotEnd  = evt.sclFall && engaged && (bitCnt == END_CNT);
  assign decided  = !ackReq && !eventFlag;

  always_comb begin
    ctl.latchByte = accept;
    ctl.holdScl   = slotOpen && !decided;
    ctl.freeScl   = (waitSlot && decided) || evt.start || evt.stop;
    ctl.pullSda   = ackBit && decided && (slotOpen || waitSlot);
    ctl.freeSda   = slotEnd || evt.start || evt.stop;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      ackBit    <= 1'b0;
      waitSlot  <= 1'b0;
      eventFlag <= 1'b0;
      ackReq    <= 1'b0;
      rxIsAddr  <= 1'b0;
      rxActive  <= 1'b0;
      txSwitch  <= 1'b0;
    end else begin
      if (ackWr) begin
        ackReq <= 1'b0;
        ackBit <= ackVal;
      end
      if (flagClr) eventFlag <= 1'b0;
      if (dataWr && rxActive) txSwitch <= 1'b1;
      if (evt.start || evt.stop) begin
        state    <= evt.start ? ST_ADDR : ST_IDLE;
        bitCnt   <= '0;
        waitSlot <= 1'b0;
        rxActive <= 1'b0;
        txSwitch <= 1'b0;
      end else begin
        if (evt.sclRise && engaged && (bitCnt != END_CNT)) bitCnt <= bitCnt + 1'b1;
        if (byteDone) begin
          if (accept) begin
            eventFlag <= 1'b1;
            ackReq    <= 1'b1;
            rxIsAddr  <= (state == ST_ADDR);
            if (state == ST_ADDR) rxActive <= 1'b1;
          end else begin
            state <= ST_SKIP;
          end
        end
        if (slotOpen && !decided)     waitSlot <= 1'b1;
        else if (waitSlot && decided) waitSlot <= 1'b0;
        if (slotEnd) begin
          bitCnt <= '0;
          if (state == ST_ADDR) begin
            if (ackBit) state <= ST_DATA;
            else begin
              state    <= ST_SKIP;
              rxActive <= 1'b0;
            end
          end
        end
      end
    end
  end

  // R8: an inhibited address never raises the event flag
  a_r8_inhibit_no_event: assert property (@(posedge clk) disable iff (!rstN)
    (byteDone && (state == ST_ADDR) && inhibit) |=> !$rose(eventFlag));
  // R6: a skipped transfer stays silent until a START
  a_r6_skip_silent: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_SKIP) && !evt.start) |=> !$rose(eventFlag));
endmodule

// File: rtl/twi_slave_rx.sv
module twi_slave_rx import twi_rx_pkg::*; #(
  parameter int SYNC_N = 2,
  parameter int FILT_N = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              inhibit,
  input  logic              ackWr,
  input  logic              ackVal,
  input  logic              flagClr,
  input  logic              dataWr,
  output logic              sclHoldLow,
  output logic              sdaPullLow,
  output logic              eventFlag,
  output logic              ackReq,
  output logic              rxIsAddr,
  output logic              rxActive,
  output logic              txSwitch,
  output logic [BYTE_W-1:0] rxData
);
  busEvt_t evt;
  dpCtl_t  ctl;
  logic    curBit;

  twi_rx_dpath #(.SYNC_N(SYNC_N), .FILT_N(FILT_N)) u_dpath (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .ctl(ctl),
    .evt(evt), .curBit(curBit), .rxData(rxData),
    .sdaPullLow(sdaPullLow), .sclHoldLow(sclHoldLow)
  );

  twi_rx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .evt(evt), .curBit(curBit), .inhibit(inhibit),
    .ackWr(ackWr), .ackVal(ackVal), .flagClr(flagClr), .dataWr(dataWr),
    .ctl(ctl), .eventFlag(eventFlag), .ackReq(ackReq), .rxIsAddr(rxIsAddr),
    .rxActive(rxActive), .txSwitch(txSwitch)
  );

  // R2: events only rise inside receive mode
  a_r2_event_in_rx: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eventFlag) |-> rxActive);
  // R4: stretching starts only with a decision pending
  a_r4_hold_needs_pending: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclHoldLow) |-> (eventFlag || ackReq));
  // R4: stretching ends only once the host has answered
  a_r4_release_after_answer: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sclHoldLow) |-> (!eventFlag && !ackReq));
  // R11: the transmit request follows a host data write
  a_r11_tx_from_write: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txSwitch) |-> $past(dataWr));
endmodule

// File: tb/twi_slave_rx_tb_top.sv
module twi_slave_rx_tb_top;
  localparam int Q = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1, mSda = 1'b1;
  logic inhibit = 1'b0, ackWr = 1'b0, ackVal = 1'b0, flagClr = 1'b0, dataWr = 1'b0;
  logic sclHoldLow, sdaPullLow, eventFlag, ackReq, rxIsAddr, rxActive, txSwitch;
  logic [7:0] rxData;
  logic sclBus, sdaBus;
  logic lastHighFlag = 1'b0;
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  assign sclBus = mScl & ~sclHoldLow;
  assign sdaBus = mSda & ~sdaPullLow;

  twi_slave_rx dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclBus), .sdaIn(sdaBus), .inhibit(inhibit),
    .ackWr(ackWr), .ackVal(ackVal), .flagClr(flagClr), .dataWr(dataWr),
    .sclHoldLow(sclHoldLow), .sdaPullLow(sdaPullLow), .eventFlag(eventFlag),
    .ackReq(ackReq), .rxIsAddr(rxIsAddr), .rxActive(rxActive),
    .txSwitch(txSwitch), .rxData(rxData)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitSclHigh();
    while (!sclBus) tick(1);
  endtask

  task automatic pulseFlagClr();
    @(negedge clk); flagClr = 1'b1;
    @(negedge clk); flagClr = 1'b0;
  endtask

  task automatic pulseAck(input logic v);
    @(negedge clk); ackVal = v; ackWr = 1'b1;
    @(negedge clk); ackWr = 1'b0;
  endtask

  task automatic masterBit(input logic b, input bit early, input logic earlyVal, input bit glitch);
    mSda = b;
    if (glitch) begin
      tick(Q / 2); mScl = 1'b1; tick(2); mScl = 1'b0; tick(Q / 2);
    end else tick(Q);
    mScl = 1'b1;
    waitSclHigh();
    tick(2 * Q);
    lastHighFlag = eventFlag;
    if (early) begin
      pulseFlagClr();
      pulseAck(earlyVal);
    end
    mScl = 1'b0;
    tick(Q);
  endtask

  task automatic send8(input logic [7:0] b, input bit early, input logic earlyVal, input int glitchAt);
    for (int i = 7; i >= 0; i--) masterBit(b[i], early && (i == 0), earlyVal, i == glitchAt);
  endtask

  task automatic ackClock(output logic seen);
    mSda = 1'b1;
    tick(Q);
    mScl = 1'b1;
    waitSclHigh();
    tick(Q);
    seen = sdaBus;
    tick(Q);
    mScl = 1'b0;
    tick(Q);
  endtask

  task automatic masterStart();
    mSda = 1'b1; tick(Q);
    mScl = 1'b1; tick(Q);
    mSda = 1'b0; tick(Q);
    mScl = 1'b0; tick(Q);
  endtask

  task automatic masterStop();
    mSda = 1'b0; tick(Q);
    mScl = 1'b1; tick(Q);
    mSda = 1'b1; tick(2 * Q);
  endtask

  // host answers during a stretch, with exact release timing
  task automatic stretchedAnswer(input string tag, input logic v);
    chk({tag, " R4 hold asserted"}, sclHoldLow, 1'b1);
    pulseFlagClr();
    chk({tag, " R4 hold kept with ack pending"}, sclHoldLow, 1'b1);
    @(negedge clk); ackVal = v; ackWr = 1'b1;
    @(negedge clk); ackWr = 1'b0;
    chk({tag, " R4 hold one clock after answer"}, sclHoldLow, 1'b1);
    @(negedge clk);
    chk({tag, " R4 hold released"}, sclHoldLow, 1'b0);
    chk({tag, " R3 data level with release"}, sdaPullLow, v);
  endtask

  task automatic testReset();
    chk("R1 sclHoldLow", sclHoldLow, 1'b0);
    chk("R1 sdaPullLow", sdaPullLow, 1'b0);
    chk("R1 flags", {eventFlag, ackReq, rxIsAddr, rxActive, txSwitch}, 5'b0);
    chk("R1 rxData", rxData, 8'h00);
  endtask

  task automatic testWriteSequence();
    logic seen;
    masterStart();
    send8(8'hB4, 1'b0, 1'b0, -1);
    chk("R2 event before ninth clock", lastHighFlag, 1'b1);
    chk("R2 ackReq", ackReq, 1'b1);
    chk("R2 rxIsAddr", rxIsAddr, 1'b1);
    chk("R2 rxActive", rxActive, 1'b1);
    chk("R2 rxData address", rxData, 8'hB4);
    stretchedAnswer("addr", 1'b1);
    ackClock(seen);
    chk("R3 address ACK low", seen, 1'b0);
    chk("R3 data line freed after slot", sdaPullLow, 1'b0);
    // data byte answered early: no stretch
    send8(8'h3C, 1'b1, 1'b1, -1);
    chk("R7 data event before ninth clock", lastHighFlag, 1'b1);
    chk("R7 rxIsAddr clear", rxIsAddr, 1'b0);
    chk("R7 rxData byte1", rxData, 8'h3C);
    tick(Q);
    chk("R5 no stretch when decided", sclHoldLow, 1'b0);
    ackClock(seen);
    chk("R5 early ACK low", seen, 1'b0);
    // data byte refused through a stretch
    send8(8'hE1, 1'b0, 1'b0, -1);
    chk("R7 rxData byte2", rxData, 8'hE1);
    stretchedAnswer("data", 1'b0);
    ackClock(seen);
    chk("R3 data NACK high", seen, 1'b1);
    chk("R7 still active after data NACK", rxActive, 1'b1);
    masterStop();
    chk("R10 inactive after STOP", rxActive, 1'b0);
    send8(8'hB4, 1'b0, 1'b0, -1);
    chk("R10 no event after STOP", eventFlag, 1'b0);
    ackClock(seen);
    chk("R10 no ACK after STOP", seen, 1'b1);
    masterStop();
  endtask

  task automatic testAddrNack();
    logic seen;
    masterStart();
    send8(8'hB4, 1'b0, 1'b0, -1);
    chk("R6 address event", eventFlag, 1'b1);
    stretchedAnswer("nack", 1'b0);
    ackClock(seen);
    chk("R6 address refused high", seen, 1'b1);
    chk("R6 rxActive cleared", rxActive, 1'b0);
    send8(8'h11, 1'b0, 1'b0, -1);
    chk("R6 no event after refusal", eventFlag, 1'b0);
    chk("R6 no stretch after refusal", sclHoldLow, 1'b0);
    ackClock(seen);
    chk("R6 no ACK after refusal", seen, 1'b1);
    masterStart();
    send8(8'hB4, 1'b0, 1'b0, -1);
    chk("R6 event after repeated START", eventFlag, 1'b1);
    stretchedAnswer("restart", 1'b1);
    ackClock(seen);
    chk("R6 ACK after repeated START", seen, 1'b0);
    masterStop();
  endtask

  task automatic testInhibit();
    logic seen;
    inhibit = 1'b1;
    masterStart();
    send8(8'hB4, 1'b0, 1'b0, -1);
    chk("R8 no event when inhibited", eventFlag, 1'b0);
    chk("R8 not active when inhibited", rxActive, 1'b0);
    chk("R8 no stretch when inhibited", sclHoldLow, 1'b0);
    ackClock(seen);
    chk("R8 no ACK when inhibited", seen, 1'b1);
    inhibit = 1'b0;
    masterStop();
  endtask

  task automatic testRead();
    logic seen;
    masterStart();
    send8(8'hB5, 1'b0, 1'b0, -1);
    chk("R9 no event on read", eventFlag, 1'b0);
    chk("R9 no stretch on read", sclHoldLow, 1'b0);
    ackClock(seen);
    chk("R9 no ACK on read", seen, 1'b1);
    masterStop();
  endtask

  task automatic testTxSwitch();
    logic seen;
    @(negedge clk); dataWr = 1'b1;
    @(negedge clk); dataWr = 1'b0;
    tick(1);
    chk("R11 write while idle ignored", txSwitch, 1'b0);
    masterStart();
    send8(8'hB4, 1'b0, 1'b0, -1);
    stretchedAnswer("tx", 1'b1);
    ackClock(seen);
    @(negedge clk); dataWr = 1'b1;
    @(negedge clk); dataWr = 1'b0;
    chk("R11 switch request set", txSwitch, 1'b1);
    masterStop();
    chk("R11 switch request cleared by STOP", txSwitch, 1'b0);
  endtask

  task automatic testGlitch();
    logic seen;
    masterStart();
    send8(8'hB4, 1'b0, 1'b0, 4);
    chk("R12 glitch ignored, address intact", rxData, 8'hB4);
    chk("R12 event after glitched byte", eventFlag, 1'b1);
    stretchedAnswer("glitch", 1'b1);
    ackClock(seen);
    chk("R12 ACK on ninth clock", seen, 1'b0);
    masterStop();
  endtask

  initial begin
    tick(5);
    rstN = 1'b1;
    tick(2);
    testReset();
    testWriteSequence();
    testAddrNack();
    testInhibit();
    testRead();
    testTxSwitch();
    testGlitch();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule